// File: doc/BRIEF.md
# Flash and Torch LED Current Sequencer

This block decides, cycle by cycle, which current step each of a small set of LED current channels should drive and whether the channel is switched on. It supports four operating modes selected by a two-bit mode field: off, privacy indication, torch and flash. Torch and flash currents come from per-channel codes. Every turn-on climbs one step at a time from the lowest step, so inrush stays bounded. A flash always passes through every torch step before it enters the flash steps.

A flash is started either by writing the flash mode or by an active edge on a strobe pin. A strobe flash is level-sensitive or edge-triggered. A flash ends on a programmable timeout, on strobe release in level mode, or on a mode write of off. When a flash ends, the outputs drop to zero and the mode field returns to off. A transmit-interrupt pin can temporarily cap the flash current at the torch step. All timing counts a one-microsecond tick input. The parameters STEP_US and UNIT_US set the step interval and the timeout unit, and can be made small for simulation.

Levels are reported on one unified scale: torch code t maps to level t (0..7), and flash code f maps to level 8+f (8..23).

Top module: `led_drive_seq`

## Requirements
- R1: `mode_q` reports the active mode as 00 off, 01 privacy, 10 torch, 11 flash. Reset leaves it at 00 with all channels off and at level 0. In privacy mode every enabled channel is on at level 0.
- R2: Each channel reports its level on `led_level[5i+4:5i]`. Torch code t (3 bits at `torch_codes[3i+2:3i]`) maps to level t. Flash code f (4 bits at `flash_codes[4i+3:4i]`) maps to level 8+f.
- R3: A mode write accepted at clock edge e enters the new mode at that edge, with every channel at level 0. After edge e+j a channel shows level min(floor(j/STEP_US), target) when one tick arrives per cycle.
- R4: In torch mode the ramp stops at the torch target. Lowering the torch code while in torch mode moves the level down to the new target at the next edge.
- R5: A flash entered at edge e stays on through edge e+L-1, where L = (timeout_code+1)·UNIT_US ticks. At edge e+L it ends and `timeout_evt` is high for exactly one cycle.
- R6: With `strobe_edge`=0, a strobe flash ends 3 edges after the strobe pin goes inactive, with no timeout event. A new active edge starts a fresh flash from level 0 with a fresh timeout.
- R7: With `strobe_edge`=1, a strobe flash ends only at its timeout. Releasing the strobe pin and writing mode 00 have no effect on it.
- R8: Writing mode 00 during a flash started by a mode write ends it at that edge, with no timeout event.
- R9: During a flash, an active TX pin (active level = `tx_pol`) caps each channel at its torch level, 2 edges after the pin change. Releasing TX restores the ramp level 2 edges after release. The timeout still ends the flash while TX is active.
- R10: At the end of any flash all channels are off at level 0 and `mode_q` is 00, even if torch was active before the flash.
- R11: A channel whose `led_en` bit is 0 stays off at level 0 in every mode. The other channels are unaffected.
- R12: A strobe active edge (active level = `strobe_pol`) starts a flash 3 edges after the pin change, and only while `strobe_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value to write |
| mode_q | output | 2 | Current mode field |
| led_en | input | NLED | Per-channel enable |
| torch_codes | input | 3·NLED | Torch codes, channel i at [3i+2:3i] |
| flash_codes | input | 4·NLED | Flash codes, channel i at [4i+3:4i] |
| timeout_code | input | 5 | Flash timeout code |
| strobe_pin | input | 1 | Asynchronous strobe pin |
| strobe_en | input | 1 | Strobe trigger enable |
| strobe_pol | input | 1 | Strobe active level |
| strobe_edge | input | 1 | 1 = edge-triggered, 0 = level-sensitive |
| tx_pin | input | 1 | Asynchronous transmit-interrupt pin |
| tx_pol | input | 1 | TX active level |
| led_level | output | 5·NLED | Unified current level per channel |
| led_on | output | NLED | Channel on |
| timeout_evt | output | 1 | One-cycle pulse when a flash times out |

## Verification
The assertions assume the polarity, enable and edge-mode controls and the timeout code stay steady while a flash runs. They also assume a polarity is changed only while its trigger is disabled, so that a polarity flip is never taken for a pin edge. The stimulus changes these controls only between flashes and holds `strobe_en` low while `strobe_pol` changes. Pins and mode writes are driven shortly after a clock edge and held for whole cycles, so the synchronizer latencies in R6, R9 and R12 are exact.

// File: rtl/led_seq_pkg.sv
`timescale 1ns/1ps
package led_seq_pkg;

  localparam int LVL_W   = 5;
  localparam int TCODE_W = 3;
  localparam int FCODE_W = 4;
  localparam int TO_W    = 5;
  localparam int N_TORCH = 1 << TCODE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PRIV  = 2'b01,
    ST_TORCH = 2'b10,
    ST_FLASH = 2'b11
  } seq_st_e;

  function automatic logic [LVL_W-1:0] torch_level(input logic [TCODE_W-1:0] code);
    return LVL_W'(code);
  endfunction

  function automatic logic [LVL_W-1:0] flash_level(input logic [FCODE_W-1:0] code);
    return LVL_W'(N_TORCH) + LVL_W'(code);
  endfunction

  function automatic int unsigned timeout_ticks(input logic [TO_W-1:0] code,
                                                input int unsigned unit);
    return (int'(code) + 1) * unit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign pin_out = sync_q;
endmodule

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer
  import led_seq_pkg::*;
#(
  parameter int STEP_US = 32,
  parameter int UNIT_US = 32000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            restart,
  input  logic            run_to,
  input  logic [TO_W-1:0] to_code,
  output logic            step,
  output logic            expire
);
  localparam int STEP_CW = $clog2(STEP_US + 1);
  localparam int TO_MAX  = (1 << TO_W) * UNIT_US;
  localparam int TO_CW   = $clog2(TO_MAX + 1);
  localparam logic [STEP_CW-1:0] STEP_LAST = STEP_CW'(STEP_US - 1);

  logic [STEP_CW-1:0] step_cnt;
  logic [TO_CW-1:0]   to_cnt;
  logic [TO_CW-1:0]   limit;

  assign limit = TO_CW'(timeout_ticks(to_code, UNIT_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
    end else if (restart) begin
      step_cnt <= '0;
    end else if (tick) begin
      step_cnt <= (step_cnt == STEP_LAST) ? '0 : step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cnt <= '0;
    end else if (restart || !run_to) begin
      to_cnt <= '0;
    end else if (tick) begin
      to_cnt <= to_cnt + 1'b1;
    end
  end

  assign step   = tick && !restart && (step_cnt == STEP_LAST);
  assign expire = run_to && tick && !restart && (to_cnt == limit - 1'b1);

  // R5
  to_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_to && $stable(to_code) && $past(run_to) && !restart) |-> (to_cnt < limit));
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import led_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       stb_act,
  input  logic       stb_rise,
  input  logic       stb_en,
  input  logic       stb_edge,
  input  logic       expire,
  output seq_st_e    st,
  output logic       restart,
  output logic       timeout_evt
);
  seq_st_e st_q, st_n;
  logic    own_q, own_n;     // flash started by strobe
  logic    edg_q, edg_n;     // that strobe flash is edge-triggered
  logic    evt_q, evt_n;
  logic    stb_go;
  logic    edge_hold;

  assign edge_hold = (st_q == ST_FLASH) && own_q && edg_q;
  assign stb_go    = stb_en && stb_rise && !edge_hold;

  always_comb begin
    st_n    = st_q;
    own_n   = own_q;
    edg_n   = edg_q;
    evt_n   = 1'b0;
    restart = 1'b0;
    if (stb_go) begin
      st_n    = ST_FLASH;
      own_n   = 1'b1;
      edg_n   = stb_edge;
      restart = 1'b1;
    end else if (st_q == ST_FLASH) begin
      if (expire) begin
        st_n  = ST_IDLE;
        evt_n = 1'b1;
      end else if (own_q && !edg_q && !stb_act) begin
        st_n = ST_IDLE;
      end else if (mode_wr && (mode_wdata == 2'b00) && !edge_hold) begin
        st_n = ST_IDLE;
      end
    end else if (mode_wr) begin
      st_n    = seq_st_e'(mode_wdata);
      own_n   = 1'b0;
      restart = (st_n != st_q) && (st_n != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      own_q <= 1'b0;
      edg_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      own_q <= own_n;
      edg_q <= edg_n;
      evt_q <= evt_n;
    end
  end

  assign st          = st_q;
  assign timeout_evt = evt_q;

  // R5
  evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (st_q == ST_IDLE));

  // R7
  edge_only_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_FLASH && $past(own_q && edg_q) && st_q != ST_FLASH) |-> timeout_evt);
endmodule

// File: rtl/ramp_chan.sv
`timescale 1ns/1ps
module ramp_chan
  import led_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic             step,
  input  logic [LVL_W-1:0] tgt,
  input  logic             en,
  input  logic             force_t,
  input  logic [LVL_W-1:0] torch_lvl,
  output logic [LVL_W-1:0] level,
  output logic             on
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] capped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (restart || !active) begin
      lvl_q <= '0;
    end else if (lvl_q > tgt) begin
      lvl_q <= tgt;
    end else if (step && (lvl_q < tgt)) begin
      lvl_q <= lvl_q + 1'b1;
    end
  end

  assign capped = (force_t && (lvl_q > torch_lvl)) ? torch_lvl : lvl_q;
  assign on     = active && en;
  assign level  = on ? capped : '0;

  // R3
  ramp_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q > $past(lvl_q)) |-> (lvl_q == $past(lvl_q) + 1'b1));
endmodule

// File: rtl/led_drive_seq.sv
`timescale 1ns/1ps
module led_drive_seq
  import led_seq_pkg::*;
#(
  parameter int NLED    = 2,
  parameter int STEP_US = 32,
  parameter int UNIT_US = 32000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_us,
  input  logic                    mode_wr,
  input  logic [1:0]              mode_wdata,
  output logic [1:0]              mode_q,
  input  logic [NLED-1:0]         led_en,
  input  logic [NLED*TCODE_W-1:0] torch_codes,
  input  logic [NLED*FCODE_W-1:0] flash_codes,
  input  logic [TO_W-1:0]         timeout_code,
  input  logic                    strobe_pin,
  input  logic                    strobe_en,
  input  logic                    strobe_pol,
  input  logic                    strobe_edge,
  input  logic                    tx_pin,
  input  logic                    tx_pol,
  output logic [NLED*LVL_W-1:0]   led_level,
  output logic [NLED-1:0]         led_on,
  output logic                    timeout_evt
);
  logic [1:0] pins_s;
  logic       stb_act, stb_prev, stb_rise;
  logic       tx_act, tx_force;
  logic       step, expire, restart;
  logic       active, flashing;
  seq_st_e    st;

  pin_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in ({tx_pin, strobe_pin}),
    .pin_out(pins_s)
  );

  assign stb_act = strobe_pol ? pins_s[0] : ~pins_s[0];
  assign tx_act  = tx_pol     ? pins_s[1] : ~pins_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= 1'b0;
    else        stb_prev <= stb_act;
  end
  assign stb_rise = stb_act && !stb_prev;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .stb_act    (stb_act),
    .stb_rise   (stb_rise),
    .stb_en     (strobe_en),
    .stb_edge   (strobe_edge),
    .expire     (expire),
    .st         (st),
    .restart    (restart),
    .timeout_evt(timeout_evt)
  );

  assign active   = (st != ST_IDLE);
  assign flashing = (st == ST_FLASH);
  assign tx_force = flashing && tx_act;
  assign mode_q   = st;

  seq_timer #(.STEP_US(STEP_US), .UNIT_US(UNIT_US)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_us),
    .restart(restart),
    .run_to (flashing),
    .to_code(timeout_code),
    .step   (step),
    .expire (expire)
  );

  for (genvar i = 0; i < NLED; i++) begin : g_chan
    logic [LVL_W-1:0] t_lvl, f_lvl, tgt;

    assign t_lvl = torch_level(torch_codes[i*TCODE_W +: TCODE_W]);
    assign f_lvl = flash_level(flash_codes[i*FCODE_W +: FCODE_W]);

    always_comb begin
      unique case (st)
        ST_TORCH: tgt = t_lvl;
        ST_FLASH: tgt = f_lvl;
        default:  tgt = '0;
      endcase
    end

    ramp_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .active   (active),
      .step     (step),
      .tgt      (tgt),
      .en       (led_en[i]),
      .force_t  (tx_force),
      .torch_lvl(t_lvl),
      .level    (led_level[i*LVL_W +: LVL_W]),
      .on       (led_on[i])
    );

    // R11
    chan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !led_en[i] |-> (!led_on[i] && led_level[i*LVL_W +: LVL_W] == '0));
  end

  // R10
  flash_end_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'b11 && mode_q == 2'b00) |-> (led_on == '0));
endmodule

// File: tb/tb_led_drive_seq.sv
`timescale 1ns/1ps
module tb_led_drive_seq;
  localparam int NLED = 2;
  localparam int P    = 2;
  localparam int U    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic [1:0] mode_q;
  logic [NLED-1:0] led_en = 2'b11;
  logic [NLED*3-1:0] torch_codes = '0;
  logic [NLED*4-1:0] flash_codes = '0;
  logic [4:0] timeout_code = '0;
  logic strobe_pin = 1'b0, strobe_en = 1'b0, strobe_pol = 1'b1, strobe_edge = 1'b0;
  logic tx_pin = 1'b0, tx_pol = 1'b1;
  logic [NLED*5-1:0] led_level;
  logic [NLED-1:0] led_on;
  logic timeout_evt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  led_drive_seq #(.NLED(NLED), .STEP_US(P), .UNIT_US(U)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .mode_q(mode_q), .led_en(led_en),
    .torch_codes(torch_codes), .flash_codes(flash_codes),
    .timeout_code(timeout_code), .strobe_pin(strobe_pin), .strobe_en(strobe_en),
    .strobe_pol(strobe_pol), .strobe_edge(strobe_edge), .tx_pin(tx_pin),
    .tx_pol(tx_pol), .led_level(led_level), .led_on(led_on),
    .timeout_evt(timeout_evt)
  );

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int lv(input int i);
    return int'(led_level[i*5 +: 5]);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1'b1;
    mode_wdata = m;
    adv(1);
    mode_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    adv(3);
    // R1 reset state
    chk("R1 reset mode", int'(mode_q), 0);
    chk("R1 reset on", int'(led_on), 0);
    chk("R1 reset level", int'(led_level), 0);
    chk("R1 reset evt", int'(timeout_evt), 0);
    rst_n = 1'b1;
    adv(4);

    // R3 R4 R2 torch ramp sweep over all torch codes
    for (int t = 0; t < 8; t++) begin
      torch_codes = {3'(7 - t), 3'(t)};
      wr_mode(2'b10);
      chk("R1 torch mode", int'(mode_q), 2);
      for (int j = 0; j <= 18; j++) begin
        chk("R3 R4 torch led0", lv(0), imin(j / P, t));
        chk("R3 R4 torch led1", lv(1), imin(j / P, 7 - t));
        chk("R3 torch on", int'(led_on), 3);
        adv(1);
      end
      wr_mode(2'b00);
      chk("R1 off after write", int'(led_on), 0);
      adv(1);
    end

    // R4 lowering torch target
    torch_codes = {3'd7, 3'd7};
    wr_mode(2'b10);
    adv(16);
    chk("R4 top torch", lv(0), 7);
    torch_codes = {3'd2, 3'd2};
    adv(1);
    chk("R4 lowered led0", lv(0), 2);
    chk("R4 lowered led1", lv(1), 2);
    wr_mode(2'b00);
    adv(1);

    // R2 R3 R5 flash ramp sweep over all flash codes
    timeout_code = 5'd3;
    for (int f = 0; f < 16; f++) begin
      flash_codes = {4'(15 - f), 4'(f)};
      wr_mode(2'b11);
      for (int j = 0; j < 80; j++) begin
        chk("R2 R3 flash led0", lv(0), imin(j / P, 8 + f));
        chk("R2 R3 flash led1", lv(1), imin(j / P, 23 - f));
        chk("R5 flash on", int'(led_on), 3);
        adv(1);
      end
      chk("R5 off at limit", int'(led_on), 0);
      chk("R5 evt at limit", int'(timeout_evt), 1);
      chk("R10 mode cleared", int'(mode_q), 0);
      adv(1);
      chk("R5 evt one cycle", int'(timeout_evt), 0);
    end

    // R5 timeout duration sweep
    for (int c = 0; c < 32; c++) begin
      int n;
      timeout_code = 5'(c);
      wr_mode(2'b11);
      n = 0;
      while (led_on != 0 && n < 1000) begin
        adv(1);
        n++;
      end
      chk("R5 duration", n, (c + 1) * U);
      chk("R5 evt", int'(timeout_evt), 1);
      adv(1);
    end

    // R8 write 00 ends software flash
    timeout_code = 5'd2;
    wr_mode(2'b11);
    adv(10);
    wr_mode(2'b00);
    chk("R8 off", int'(led_on), 0);
    chk("R8 mode", int'(mode_q), 0);
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 70; j++) begin
        if (timeout_evt) seen++;
        adv(1);
      end
      chk("R8 no evt", seen, 0);
    end

    // R10 torch then flash ends fully off
    torch_codes = {3'd4, 3'd4};
    timeout_code = 5'd0;
    wr_mode(2'b10);
    adv(5);
    wr_mode(2'b11);
    adv(U);
    chk("R10 off", int'(led_on), 0);
    chk("R10 mode", int'(mode_q), 0);
    adv(10);
    chk("R10 stays off", int'(led_on), 0);
    chk("R10 level", int'(led_level), 0);

    // R9 TX force, active high
    flash_codes = {4'd5, 4'd12};
    torch_codes = {3'd3, 3'd6};
    timeout_code = 5'd7;
    wr_mode(2'b11);
    adv(60);
    tx_pin = 1'b1;
    adv(1);
    chk("R9 not yet led0", lv(0), 20);
    adv(1);
    chk("R9 forced led0", lv(0), 6);
    chk("R9 forced led1", lv(1), 3);
    adv(8);
    tx_pin = 1'b0;
    adv(1);
    chk("R9 still forced", lv(0), 6);
    adv(1);
    chk("R9 restored led0", lv(0), 20);
    chk("R9 restored led1", lv(1), 13);
    adv(8);
    tx_pin = 1'b1;
    adv(79);
    chk("R9 on before limit", int'(led_on), 3);
    chk("R9 forced late", lv(0), 6);
    adv(1);
    chk("R9 timeout under tx", int'(led_on), 0);
    chk("R9 evt under tx", int'(timeout_evt), 1);
    tx_pin = 1'b1;
    tx_pol = 1'b0;
    adv(4);

    // R9 TX active low during ramp
    wr_mode(2'b11);
    adv(20);
    tx_pin = 1'b0;
    adv(2);
    chk("R9 low pol led0", lv(0), 6);
    chk("R9 low pol led1", lv(1), 3);
    tx_pin = 1'b1;
    adv(2);
    chk("R9 low pol release", lv(0), 12);
    wr_mode(2'b00);
    tx_pol = 1'b1;
    tx_pin = 1'b0;
    adv(4);

    // R6 R12 level-sensitive strobe with toggle restart
    flash_codes = {4'd0, 4'd0};
    timeout_code = 5'd0;
    strobe_en = 1'b1;
    strobe_edge = 1'b0;
    strobe_pin = 1'b1;
    adv(2);
    chk("R12 not yet", int'(led_on), 0);
    adv(1);
    chk("R12 strobe on", int'(led_on), 3);
    chk("R12 strobe mode", int'(mode_q), 3);
    chk("R6 start level", lv(0), 0);
    adv(12);
    strobe_pin = 1'b0;
    adv(2);
    chk("R6 before end", int'(led_on), 3);
    strobe_pin = 1'b1;
    adv(1);
    chk("R6 ended", int'(led_on), 0);
    chk("R6 no evt", int'(timeout_evt), 0);
    chk("R6 mode", int'(mode_q), 0);
    adv(2);
    chk("R6 restarted", int'(led_on), 3);
    chk("R6 restart level", lv(0), 0);
    adv(8);
    chk("R6 past old limit", int'(led_on), 3);
    chk("R6 ramp after restart", lv(0), 4);
    adv(11);
    chk("R6 before new limit", int'(led_on), 3);
    adv(1);
    chk("R6 new limit", int'(led_on), 0);
    chk("R6 evt", int'(timeout_evt), 1);
    strobe_pin = 1'b0;
    adv(4);

    // R7 edge-triggered strobe
    strobe_edge = 1'b1;
    strobe_pin = 1'b1;
    adv(3);
    chk("R7 on", int'(led_on), 3);
    adv(2);
    strobe_pin = 1'b0;
    adv(3);
    wr_mode(2'b00);
    chk("R7 ignores release and write", int'(led_on), 3);
    chk("R7 mode kept", int'(mode_q), 3);
    adv(13);
    chk("R7 before limit", int'(led_on), 3);
    adv(1);
    chk("R7 limit", int'(led_on), 0);
    chk("R7 evt", int'(timeout_evt), 1);
    strobe_edge = 1'b0;
    adv(2);

    // R12 strobe disabled
    strobe_en = 1'b0;
    strobe_pin = 1'b1;
    adv(10);
    chk("R12 disabled", int'(led_on), 0);
    strobe_pin = 1'b0;
    adv(4);

    // R12 active-low strobe
    strobe_pol = 1'b0;
    strobe_pin = 1'b1;
    adv(4);
    strobe_en = 1'b1;
    adv(2);
    chk("R12 no spurious", int'(led_on), 0);
    strobe_pin = 1'b0;
    adv(2);
    chk("R12 low not yet", int'(led_on), 0);
    adv(1);
    chk("R12 low on", int'(led_on), 3);
    strobe_pin = 1'b1;
    adv(2);
    chk("R6 low still on", int'(led_on), 3);
    adv(1);
    chk("R6 low ended", int'(led_on), 0);
    chk("R6 low no evt", int'(timeout_evt), 0);
    strobe_en = 1'b0;
    strobe_pol = 1'b1;
    strobe_pin = 1'b0;
    adv(4);

    // R11 per-channel enable
    led_en = 2'b01;
    torch_codes = {3'd5, 3'd5};
    wr_mode(2'b10);
    adv(12);
    chk("R11 led0 level", lv(0), 5);
    chk("R11 led1 level", lv(1), 0);
    chk("R11 on", int'(led_on), 1);
    wr_mode(2'b00);
    adv(1);

    // R1 privacy
    led_en = 2'b10;
    wr_mode(2'b01);
    chk("R1 privacy mode", int'(mode_q), 1);
    adv(20);
    chk("R1 privacy on", int'(led_on), 2);
    chk("R1 privacy level", int'(led_level), 0);
    wr_mode(2'b00);
    chk("R1 privacy off", int'(led_on), 0);
    adv(2);

    finish_run();
  end
endmodule